// File: doc/BRIEF.md
# Processor Power-State Controller

This block follows a processor core through three power modes: running (Normal), idle after a halt instruction (Halt), and clock-stopped on request from system logic (Stop Grant). It reacts to a strobe from the core when a halt instruction retires, to an asynchronous stop request from the platform, to a wake level from interrupt logic, and to a bus-idle indication. Each entry into a low-power mode is announced on the system bus through a special bus cycle. The cycle is a request with a type code that the bus unit acknowledges.

While the core is in Halt or Stop Grant, the controller gates most of the core's internal clock distribution and floats the data and parity buses. It also drives the enable of the internal pullup on the stop-request pin. The state register, the synchronizer and the cycle request logic stay clocked in every mode, so the block keeps responding to its inputs. Stop Grant remembers the mode it came from. Leaving Stop Grant that was entered from Halt goes back to Halt and announces Halt again, without any instruction refetch.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During and after reset the block is in Normal. In that state `cyc_req_o` is 0, `core_clk_en_o` is 1, `dbus_float_o` is 0 and `stop_pullup_en_o` is 1.
- R2: A `halt_retire_i` pulse in Normal moves the block to Halt on the next clock edge. On that same edge `cyc_req_o` rises with `cyc_type_o` = 2'b01 (Halt).
- R3: In Halt and in Stop Grant, `core_clk_en_o` is 0 and `dbus_float_o` is 1. In Normal they are 1 and 0.
- R4: `stop_req_i` passes through a two-flop synchronizer. When the synchronized request is high in Halt, the block enters Stop Grant and raises `cyc_req_o` with `cyc_type_o` = 2'b10 (Stop Grant).
- R5: A synchronized stop request in Normal moves the block to Stop Grant (with a 2'b10 cycle) only while `bus_idle_i` is 1. When the request is later withdrawn, the block returns to Normal with no special cycle.
- R6: Withdrawing the stop request in a Stop Grant that was entered from Halt returns the block to Halt and issues a new Halt cycle (2'b01).
- R7: A high `wake_i` in Halt returns the block to Normal. In Stop Grant `wake_i` has no effect. In Halt a synchronized stop request takes priority over `wake_i`.
- R8: `stop_pullup_en_o` is 0 exactly when the block is out of Normal and the synchronized stop request is high. Otherwise it is 1.
- R9: `cyc_req_o` stays high with a stable `cyc_type_o` until a `cyc_ack_i` pulse arrives. It drops on the edge that samples the acknowledge. No state change occurs while a request is outstanding, so at most one request is ever pending.
- R10: A `halt_retire_i` pulse outside Normal has no effect: no new cycle is issued and the mode does not change.
- R11: Asserting `rst_n` low forces Normal outputs at once, from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_retire_i | input | 1 | One-cycle strobe: a halt instruction retired |
| stop_req_i | input | 1 | Asynchronous active-high stop-clock request |
| wake_i | input | 1 | Wake level from interrupt logic, held until serviced |
| bus_idle_i | input | 1 | No bus transaction in progress |
| cyc_ack_i | input | 1 | Acknowledge pulse for the special cycle request |
| cyc_req_o | output | 1 | Special bus cycle request |
| cyc_type_o | output | 2 | Cycle type: 01 Halt, 10 Stop Grant |
| dbus_float_o | output | 1 | Float data and parity buses |
| core_clk_en_o | output | 1 | Enable for the gated internal clock tree |
| stop_pullup_en_o | output | 1 | Enable for the stop-pin pullup |

## Verification
The bench holds the acknowledge back for many cycles and raises wake during that wait. A design that moved on a busy channel would leave Halt early or drop the Halt cycle. The bench also withdraws the stop request from both kinds of Stop Grant. A controller that forgets where it came from would either skip the Halt re-announcement or wrongly send the core to Halt after a stop that began in Normal. It drives wake during Stop Grant, wake and stop together in Halt, a stop request while the bus is busy, and a halt strobe inside Halt. Each of these exposes a wrong priority or a wrong gate as an unexpected cycle type or a wrong clock-enable level.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PM_TYPE_W = 2;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_HALT    = 2'd1,
    PM_STOPGNT = 2'd2
  } pm_state_e;

  typedef enum logic [PM_TYPE_W-1:0] {
    CYC_NONE    = 2'b00,
    CYC_HALT    = 2'b01,
    CYC_STOPGNT = 2'b10
  } pm_cyc_e;
endpackage

// File: rtl/pm_stop_sync.sv
module pm_stop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pm_cycle_req.sv
module pm_cycle_req
  import pm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    issue_i,
  input  pm_cyc_e type_i,
  input  logic    ack_i,
  output logic    req_o,
  output pm_cyc_e type_o
);
  logic    req_d;
  pm_cyc_e type_d;
  logic    type_en;

  always_comb begin
    req_d   = req_o;
    type_en = 1'b0;
    type_d  = type_i;
    if (issue_i && !req_o) begin
      req_d   = 1'b1;
      type_en = 1'b1;
    end else if (req_o && ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       type_o <= CYC_NONE;
    else if (type_en) type_o <= type_d;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(type_o)));
endmodule

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_retire_i,
  input  logic      stop_i,
  input  logic      wake_i,
  input  logic      bus_idle_i,
  input  logic      busy_i,
  output pm_state_e state_o,
  output logic      issue_o,
  output pm_cyc_e   issue_type_o
);
  pm_state_e state_q, state_d;
  logic      from_halt_q, from_halt_d, from_halt_en;

  always_comb begin
    state_d      = state_q;
    issue_o      = 1'b0;
    issue_type_o = CYC_NONE;
    from_halt_en = 1'b0;
    from_halt_d  = from_halt_q;
    if (!busy_i) begin
      unique case (state_q)
        PM_NORMAL: begin
          if (halt_retire_i) begin
            state_d      = PM_HALT;
            issue_o      = 1'b1;
            issue_type_o = CYC_HALT;
          end else if (stop_i && bus_idle_i) begin
            state_d      = PM_STOPGNT;
            issue_o      = 1'b1;
            issue_type_o = CYC_STOPGNT;
            from_halt_en = 1'b1;
            from_halt_d  = 1'b0;
          end
        end
        PM_HALT: begin
          if (stop_i) begin
            state_d      = PM_STOPGNT;
            issue_o      = 1'b1;
            issue_type_o = CYC_STOPGNT;
            from_halt_en = 1'b1;
            from_halt_d  = 1'b1;
          end else if (wake_i) begin
            state_d = PM_NORMAL;
          end
        end
        PM_STOPGNT: begin
          if (!stop_i) begin
            if (from_halt_q) begin
              state_d      = PM_HALT;
              issue_o      = 1'b1;
              issue_type_o = CYC_HALT;
            end else begin
              state_d = PM_NORMAL;
            end
          end
        end
        default: state_d = PM_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_NORMAL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            from_halt_q <= 1'b0;
    else if (from_halt_en) from_halt_q <= from_halt_d;
  end

  assign state_o = state_q;

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_HALT && $past(state_q) == PM_NORMAL) |-> $past(halt_retire_i));

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (state_q == $past(state_q)));

  // R5
  normal_stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOPGNT && $past(state_q) == PM_NORMAL) |-> $past(bus_idle_i));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_retire_i,
  input  logic                 stop_req_i,
  input  logic                 wake_i,
  input  logic                 bus_idle_i,
  input  logic                 cyc_ack_i,
  output logic                 cyc_req_o,
  output logic [PM_TYPE_W-1:0] cyc_type_o,
  output logic                 dbus_float_o,
  output logic                 core_clk_en_o,
  output logic                 stop_pullup_en_o
);
  logic      stop_sync;
  pm_state_e state_w;
  logic      issue_w;
  pm_cyc_e   issue_type_w;
  pm_cyc_e   cyc_type_w;
  logic      low_power;

  pm_stop_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (stop_req_i),
    .sync_o  (stop_sync)
  );

  pm_state_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_retire_i (halt_retire_i),
    .stop_i        (stop_sync),
    .wake_i        (wake_i),
    .bus_idle_i    (bus_idle_i),
    .busy_i        (cyc_req_o),
    .state_o       (state_w),
    .issue_o       (issue_w),
    .issue_type_o  (issue_type_w)
  );

  pm_cycle_req i_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue_w),
    .type_i  (issue_type_w),
    .ack_i   (cyc_ack_i),
    .req_o   (cyc_req_o),
    .type_o  (cyc_type_w)
  );

  assign cyc_type_o       = cyc_type_w;
  assign low_power        = (state_w != PM_NORMAL);
  assign core_clk_en_o    = !low_power;
  assign dbus_float_o     = low_power;
  assign stop_pullup_en_o = !(low_power && stop_sync);

  // R6
  sg_to_halt_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == PM_HALT && $past(state_w) == PM_STOPGNT) |-> (cyc_req_o && cyc_type_o == CYC_HALT));

  // R4
  sg_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == PM_STOPGNT && $past(state_w) != PM_STOPGNT) |-> $past(stop_sync));

  // R7
  sg_exit_stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w != PM_STOPGNT && $past(state_w) == PM_STOPGNT) |-> !$past(stop_sync));
endmodule

// File: tb/test_pwr_state_ctrl.sv
`timescale 1ns/1ps
module test_pwr_state_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       halt_retire_i, stop_req_i, wake_i, bus_idle_i, cyc_ack_i;
  logic       cyc_req_o, dbus_float_o, core_clk_en_o, stop_pullup_en_o;
  logic [1:0] cyc_type_o;

  int n_tests = 0;
  int n_fail  = 0;
  int ack_delay = 1;
  logic [1:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_retire_i(halt_retire_i), .stop_req_i(stop_req_i),
    .wake_i(wake_i), .bus_idle_i(bus_idle_i), .cyc_ack_i(cyc_ack_i), .cyc_req_o(cyc_req_o),
    .cyc_type_o(cyc_type_o), .dbus_float_o(dbus_float_o), .core_clk_en_o(core_clk_en_o),
    .stop_pullup_en_o(stop_pullup_en_o));

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected cycle types and acknowledges
  initial begin
    cyc_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && cyc_req_o && !cyc_ack_i) begin
        if (exp_q.size() == 0) begin
          check("R9 unexpected cycle", int'(cyc_type_o), 0);
        end else begin
          check("R2/R4/R6 cycle type", int'(cyc_type_o), int'(exp_q.pop_front()));
        end
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          if (!cyc_req_o) check("R9 req held", 0, 1);
        end
        cyc_ack_i = 1'b1;
        @(negedge clk);
        cyc_ack_i = 1'b0;
        check("R9 req drops after ack", int'(cyc_req_o), 0);
      end
    end
  end

  task automatic cycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !cyc_req_o && !cyc_ack_i) return;
    end
    check("R9 cycle not drained", 1, 0);
  endtask

  task automatic pulse_halt();
    halt_retire_i = 1'b1;
    @(negedge clk);
    halt_retire_i = 1'b0;
  endtask

  task automatic chk_mode(string tag, bit lowp);
    check({tag, " clk_en"}, int'(core_clk_en_o), lowp ? 0 : 1);
    check({tag, " float"},  int'(dbus_float_o),  lowp ? 1 : 0);
  endtask

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!done) begin
      check("watchdog", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; halt_retire_i = 0; stop_req_i = 0; wake_i = 0; bus_idle_i = 1;
    cycles(3);
    // R1 reset state
    check("R1 req", int'(cyc_req_o), 0);
    chk_mode("R1", 0);
    check("R1 pullup", int'(stop_pullup_en_o), 1);
    rst_n = 1'b1;
    cycles(2);

    // R2 halt entry, R3 gating
    exp_q.push_back(2'b01);
    pulse_halt();
    chk_mode("R3 halt", 1);
    wait_idle();
    // R10 halt strobe in Halt ignored
    pulse_halt();
    cycles(3);
    check("R10 no cycle", int'(cyc_req_o), 0);
    chk_mode("R10 still halt", 1);
    // R7 wake
    wake_i = 1; cycles(2); wake_i = 0;
    chk_mode("R7 wake to normal", 0);

    // R4 stop from Halt, R8 pullup
    exp_q.push_back(2'b01);
    pulse_halt();
    wait_idle();
    exp_q.push_back(2'b10);
    stop_req_i = 1;
    cycles(2);
    check("R8 pullup off", int'(stop_pullup_en_o), 0);
    wait_idle();
    chk_mode("R4 stop grant", 1);
    // R7 wake ignored in Stop Grant
    wake_i = 1; cycles(4);
    chk_mode("R7 wake ignored", 1);
    check("R7 no cycle", int'(cyc_req_o), 0);
    wake_i = 0;
    // R6 return to Halt with new Halt cycle
    exp_q.push_back(2'b01);
    stop_req_i = 0;
    wait_idle();
    cycles(2);
    chk_mode("R6 back in halt", 1);
    check("R8 pullup on", int'(stop_pullup_en_o), 1);
    wake_i = 1; cycles(2); wake_i = 0;
    chk_mode("R7 normal", 0);

    // R5 stop in Normal gated by bus idle
    bus_idle_i = 0;
    stop_req_i = 1;
    cycles(6);
    chk_mode("R5 busy bus", 0);
    check("R8 pullup in normal", int'(stop_pullup_en_o), 1);
    exp_q.push_back(2'b10);
    bus_idle_i = 1;
    wait_idle();
    chk_mode("R5 stop grant", 1);
    stop_req_i = 0;
    cycles(5);
    chk_mode("R5 back to normal", 0);
    check("R5 no cycle", int'(cyc_req_o), 0);

    // R9 wake waits for a slow ack
    ack_delay = 10;
    exp_q.push_back(2'b01);
    pulse_halt();
    wake_i = 1;
    cycles(4);
    chk_mode("R9 held in halt", 1);
    wait_idle();
    cycles(1);
    chk_mode("R9 wake after ack", 0);
    wake_i = 0;
    ack_delay = 1;

    // R7 stop beats wake in Halt
    exp_q.push_back(2'b01);
    pulse_halt();
    wait_idle();
    exp_q.push_back(2'b10);
    stop_req_i = 1; wake_i = 1;
    wait_idle();
    cycles(2);
    chk_mode("R7 stop priority", 1);
    check("R8 pullup off SG", int'(stop_pullup_en_o), 0);
    wake_i = 0;

    // R11 async reset from Stop Grant
    #1 rst_n = 1'b0;
    #0.5;
    chk_mode("R11 reset", 0);
    check("R11 req", int'(cyc_req_o), 0);
    check("R11 pullup", int'(stop_pullup_en_o), 1);
    stop_req_i = 0;
    cycles(2);
    rst_n = 1'b1;
    cycles(4);
    chk_mode("R11 after release", 0);
    check("R9 queue empty", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule